// File: doc/BRIEF.md
# Reference Divider and Phase Comparator

This block produces the comparison reference of a frequency synthesizer and compares it against the divided VCO. A free-running counter divides the incoming crystal-derived clock, `clk`, down to one of seven comparison rates. The rate is picked by a 3-bit select. Each time the count completes, the block emits a one-cycle `ref_pulse`.

A phase-frequency comparator watches `ref_pulse` and the feedback pulse `fb_pulse`, which is the divided VCO. The comparator drives an identical pump command onto every phase output:
- drive high while the reference leads;
- drive low while the feedback leads;
- high impedance otherwise.

Two override pins, `hold_hi` and `hold_lo`, can pin all outputs to a fixed level. This is used when the loop is opened. The comparator keeps running underneath the override, and its raw state is given as `phase_err` for use by an unlock detector.

The block has no data stream, so all pins are plain level or pulse signals without handshake. `fb_pulse` is a single-cycle pulse synchronous to `clk`. The select and override pins may change on any cycle.

Top module: `refdiv_pfd`

## Requirements
- R1: With the default 7.2 MHz clock, `freq_sel` codes give these spacings between `ref_pulse` pulses:

  | `freq_sel` | Rate | Spacing (cycles) |
  |---|---|---|
  | 0 | 50 kHz | 144 |
  | 1 | 25 kHz | 288 |
  | 2 | 12.5 kHz | 576 |
  | 3 | 10 kHz | 720 |
  | 4 | 9 kHz | 800 |
  | 5 | 5 kHz | 1440 |
  | 6 | 1 kHz | 7200 |
  | 7 | 1 kHz | 7200 |

  Each pulse is one cycle wide.
- R2: A change of `freq_sel` takes effect on the running count.
  - If the count has already passed the new limit, a pulse follows on the next edge.
  - Otherwise the pulse arrives when the count reaches the new spacing, counted from the last pulse.
- R3: During reset and right after it, every output is high impedance (up=0, down=0), and `phase_err` and `ref_pulse` are 0. The first `ref_pulse` appears N cycles after reset is released, where N is the spacing for the selected code.
- R4: A reference pulse with no feedback pending sets the up drive from the next cycle. The up drive holds until a feedback pulse, and clears on the cycle after that pulse.
- R5: A feedback pulse with no reference pending sets the down drive from the next cycle. The down drive holds until a reference pulse, and clears on the cycle after that pulse.
- R6: Reference and feedback pulses in the same cycle, with nothing pending, leave both drives off.
- R7: Up and down are never active together.
- R8: `phase_err` is 1 exactly while the comparator has up or down active. This holds in every override mode.
- R9: With `hold_hi`=0 and `hold_lo`=0, each output follows the comparator. Output i is encoded as follows:

  | `pd_up[i]` | `pd_dn[i]` | Output i |
  |---|---|---|
  | 1 | 0 | drive high |
  | 0 | 1 | drive low |
  | 0 | 0 | high impedance |

- R10: The override pins force every output whatever the comparator state:

  | `hold_hi` | `hold_lo` | Forced level |
  |---|---|---|
  | 1 | 0 | high |
  | 0 | 1 | low |
  | 1 | 1 | low |

- R11: All phase outputs carry the same value on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_sel | input | 3 | Comparison rate select |
| fb_pulse | input | 1 | One-cycle divided VCO pulse |
| hold_hi | input | 1 | Override: force high (unless hold_lo) |
| hold_lo | input | 1 | Override: force low |
| ref_pulse | output | 1 | One-cycle divided reference pulse |
| pd_up | output | N_OUT | Per-output drive-high command |
| pd_dn | output | N_OUT | Per-output drive-low command |
| phase_err | output | 1 | Comparator has up or down active |

## Verification
The assertions check the following on every cycle:
- mutual exclusion of up and down;
- set, hold and clear of the comparator flags on each pulse combination;
- one-cycle width of the reference pulse and the bound on the counter;
- the forced levels, `phase_err` in normal mode, and equality of all outputs.

Only the bench scenarios show the following:
- the actual spacing for every select code;
- when the first pulse arrives after reset;
- how a mid-count select change lands;
- that the comparator keeps its state through an override and resumes it afterwards.

// File: rtl/refdiv_pfd_pkg.sv
package refdiv_pfd_pkg;

  // Divide ratio for a select code given the input clock rate in Hz.
  function automatic int unsigned div_ratio(input logic [2:0] code,
                                            input int unsigned clk_hz);
    case (code)
      3'd0:    return clk_hz / 50000;
      3'd1:    return clk_hz / 25000;
      3'd2:    return (clk_hz * 2) / 25000;
      3'd3:    return clk_hz / 10000;
      3'd4:    return clk_hz / 9000;
      3'd5:    return clk_hz / 5000;
      default: return clk_hz / 1000;
    endcase
  endfunction

endpackage

// File: rtl/refdiv_pfd_divider.sv
module refdiv_pfd_divider
  import refdiv_pfd_pkg::*;
#(
  parameter int unsigned CLK_HZ = 7_200_000,
  parameter int unsigned CNT_W  = $clog2(CLK_HZ / 1000)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] freq_sel,
  output logic       ref_pulse
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             wrap;

  assign limit = CNT_W'(div_ratio(freq_sel, CLK_HZ) - 1);
  // Wrap also when a new, smaller limit has already been passed.
  assign wrap  = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      ref_pulse <= 1'b0;
    end else begin
      cnt       <= wrap ? '0 : cnt + 1'b1;
      ref_pulse <= wrap;
    end
  end

  // R1: reference pulse is one cycle wide
  a_r1_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  // R2: count never exceeds the limit while the select is steady
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(freq_sel) == freq_sel) |-> (cnt <= limit));

endmodule

// File: rtl/refdiv_pfd_core.sv
module refdiv_pfd_core (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic fb_pulse,
  output logic up,
  output logic dn
);

  logic up_nx, dn_nx;

  always_comb begin
    up_nx = up | ref_pulse;
    dn_nx = dn | fb_pulse;
    if (up_nx && dn_nx) begin
      up_nx = 1'b0;
      dn_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up_nx;
      dn <= dn_nx;
    end
  end

  // R7: never both
  a_r7_mutex: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));

  // R4: reference alone sets up, and up holds until feedback
  a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse && !fb_pulse && !dn) |=> up);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !fb_pulse) |=> up);

  // R5: feedback alone sets down, and down holds until reference
  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && !ref_pulse && !up) |=> dn);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dn && ref_pulse) |=> !dn && !up);

  // R6: coincident pulses with nothing pending leave both off
  a_r6_coincide: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse && fb_pulse && !up && !dn) |=> !up && !dn);

endmodule

// File: rtl/refdiv_pfd_drive.sv
module refdiv_pfd_drive #(
  parameter int unsigned N_OUT = 2
) (
  input  logic             up,
  input  logic             dn,
  input  logic             hold_hi,
  input  logic             hold_lo,
  output logic [N_OUT-1:0] pd_up,
  output logic [N_OUT-1:0] pd_dn
);

  logic drv_up, drv_dn;

  // Low wins when both override pins are set.
  always_comb begin
    if (hold_lo) begin
      drv_up = 1'b0;
      drv_dn = 1'b1;
    end else if (hold_hi) begin
      drv_up = 1'b1;
      drv_dn = 1'b0;
    end else begin
      drv_up = up;
      drv_dn = dn;
    end
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign pd_up[i] = drv_up;
    assign pd_dn[i] = drv_dn;
  end

endmodule

// File: rtl/refdiv_pfd.sv
module refdiv_pfd #(
  parameter int unsigned CLK_HZ = 7_200_000,
  parameter int unsigned N_OUT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       freq_sel,
  input  logic             fb_pulse,
  input  logic             hold_hi,
  input  logic             hold_lo,
  output logic             ref_pulse,
  output logic [N_OUT-1:0] pd_up,
  output logic [N_OUT-1:0] pd_dn,
  output logic             phase_err
);

  localparam int unsigned CNT_W = $clog2(CLK_HZ / 1000);

  logic cmp_up, cmp_dn;

  refdiv_pfd_divider #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .ref_pulse(ref_pulse)
  );

  refdiv_pfd_core u_core (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .up(cmp_up), .dn(cmp_dn)
  );

  refdiv_pfd_drive #(.N_OUT(N_OUT)) u_drv (
    .up(cmp_up), .dn(cmp_dn), .hold_hi(hold_hi), .hold_lo(hold_lo),
    .pd_up(pd_up), .pd_dn(pd_dn)
  );

  assign phase_err = cmp_up | cmp_dn;

  // R11: all outputs identical
  a_r11_same: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_up == {N_OUT{pd_up[0]}}) && (pd_dn == {N_OUT{pd_dn[0]}}));

  // R10: forced levels
  a_r10_low: assert property (@(posedge clk) disable iff (!rst_n)
    hold_lo |-> (pd_up == '0) && (pd_dn == '1));
  a_r10_high: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_hi && !hold_lo) |-> (pd_up == '1) && (pd_dn == '0));

  // R8 / R9: in normal mode the error flag matches the visible drive
  a_r8_err: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_hi && !hold_lo) |-> (phase_err == (pd_up[0] | pd_dn[0])));

endmodule

// File: tb/refdiv_pfd_tb.sv
module refdiv_pfd_tb;

  localparam int unsigned CLK_HZ = 7_200_000;
  localparam int unsigned N_OUT  = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       freq_sel = 3'd0;
  logic             fb_pulse = 1'b0;
  logic             hold_hi = 1'b0;
  logic             hold_lo = 1'b0;
  logic             ref_pulse;
  logic [N_OUT-1:0] pd_up, pd_dn;
  logic             phase_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5ns clk = ~clk;

  refdiv_pfd #(.CLK_HZ(CLK_HZ), .N_OUT(N_OUT)) u_dut (
    .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .fb_pulse(fb_pulse),
    .hold_hi(hold_hi), .hold_lo(hold_lo), .ref_pulse(ref_pulse),
    .pd_up(pd_up), .pd_dn(pd_dn), .phase_err(phase_err)
  );

  // Expected spacing from the rate table in the brief.
  function automatic int exp_ratio(input logic [2:0] c);
    case (c)
      3'd0: return 144;
      3'd1: return 288;
      3'd2: return 576;
      3'd3: return 720;
      3'd4: return 800;
      3'd5: return 1440;
      default: return 7200;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pack the visible state: {up bits, dn bits, err}
  function automatic int vis();
    return {pd_up, pd_dn, phase_err};
  endfunction
  localparam int ALL_Z  = 0;
  localparam int UP_ON  = {2'b11, 2'b00, 1'b1};
  localparam int DN_ON  = {2'b00, 2'b11, 1'b1};

  task automatic nedge();
    @(negedge clk);
  endtask

  task automatic wait_ref(output int n);
    n = 0;
    do begin nedge(); n++; end while (!ref_pulse);
  endtask

  task automatic fb_once();
    fb_pulse = 1'b1;
    nedge();
    fb_pulse = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000ns;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  // Scenarios
  task automatic sc_up_lead();
    int n, d;
    wait_ref(n);
    nedge();
    chk("R4 up set", vis(), UP_ON);
    d = $urandom_range(0, 40);
    repeat (d) nedge();
    chk("R4 up held", vis(), UP_ON);
    fb_once();
    chk("R4 up cleared", vis(), ALL_Z);
  endtask

  task automatic sc_dn_lead();
    int n, d;
    wait_ref(n);
    fb_once();                      // coincident with ref: nothing latched
    d = $urandom_range(5, 60);
    repeat (d) nedge();
    fb_once();
    chk("R5 down set", vis(), DN_ON);
    wait_ref(n);
    chk("R5 down held to ref", vis(), DN_ON);
    nedge();
    chk("R5 down cleared", vis(), ALL_Z);
  endtask

  task automatic sc_coincide();
    int n;
    wait_ref(n);
    fb_once();
    chk("R6 coincident", vis(), ALL_Z);
  endtask

  initial begin
    int n, k;
    void'($urandom(32'd4242));

    repeat (3) nedge();
    chk("R3 reset state", {vis(), ref_pulse}, 0);
    rst_n = 1'b1;
    chk("R3 post-reset idle", {vis(), ref_pulse}, 0);
    wait_ref(n);
    chk("R3 first pulse", n, 144);

    // R1: every code
    for (int c = 0; c < 8; c++) begin
      freq_sel = 3'(c);
      wait_ref(n);
      wait_ref(n);
      chk($sformatf("R1 spacing code %0d", c), n, exp_ratio(3'(c)));
      nedge();
      chk("R1 pulse width", int'(ref_pulse), 0);
    end

    // R2: switch after passing the new limit
    freq_sel = 3'd6;
    wait_ref(n);
    repeat (1000) nedge();
    freq_sel = 3'd0;
    wait_ref(n);
    chk("R2 immediate wrap", n, 1);
    wait_ref(n);
    chk("R2 new spacing", n, 144);
    // R2: switch before the new limit
    freq_sel = 3'd6;
    wait_ref(n);
    k = $urandom_range(1, 140);
    repeat (k) nedge();
    freq_sel = 3'd0;
    wait_ref(n);
    chk("R2 partial count", n, 144 - k);

    // R9/R10/R8/R11: overrides over an active up
    freq_sel = 3'd0;
    wait_ref(n);
    nedge();
    chk("R9 normal follows up", vis(), UP_ON);
    hold_hi = 1'b1; #1ns;
    chk("R10 force high", vis(), UP_ON);
    hold_hi = 1'b0; hold_lo = 1'b1; #1ns;
    chk("R10 force low, R8 err kept", vis(), {2'b00, 2'b11, 1'b1});
    hold_hi = 1'b1; #1ns;
    chk("R10 both set forces low", vis(), {2'b00, 2'b11, 1'b1});
    nedge();
    hold_hi = 1'b0; hold_lo = 1'b0; #1ns;
    chk("R9 state resumes after override", vis(), UP_ON);
    fb_once();
    hold_hi = 1'b1; #1ns;
    chk("R10 force high from idle, R8 err 0", vis(), {2'b11, 2'b00, 1'b0});
    hold_hi = 1'b0; #1ns;
    chk("R11 idle", vis(), ALL_Z);

    // Random mix
    for (int i = 0; i < 12; i++) begin
      freq_sel = 3'($urandom_range(0, 2));
      case ($urandom_range(0, 2))
        0: sc_up_lead();
        1: sc_dn_lead();
        default: sc_coincide();
      endcase
    end
    sc_coincide();
    sc_dn_lead();
    chk("R7 final idle", vis(), ALL_Z);

    finish_run();
  end

endmodule